// File: doc/BRIEF.md
# Scoreboard Issue and Writeback Control

This block is the central scheduling controller for a small machine with four functional units and eight architectural registers. Decoded instructions arrive one at a time, oldest first. Each one carries a class, a destination register and two source registers. The controller decides three things for each instruction: when it may enter a unit, when that unit may read its operands, and when the unit may write its result. Unit datapaths are modelled as fixed-latency countdowns, and register contents are not modelled.

Three tables hold the state. A per-unit status table holds each in-flight instruction's registers, its outstanding producers and its stage. A destination table records which unit has claimed each register. An age matrix records which in-flight instruction entered first. The outputs are single-cycle strobes for issue, operand read, execution start and writeback. The issue strobe comes with the unit index. The other three are vectors with one bit per unit. The destination of each writeback is also presented, so a register file can be steered from it.

Top module: `sched_board`

## Requirements
- R1: While reset is held, and in the first cycle after it, every read, start and writeback strobe is low, and `in_ready` is high.
- R2: Instructions enter strictly in arrival order, at most one per cycle. `issue_fire` is `in_valid & in_ready`, and `issue_unit` equals `in_cls`. A waiting head instruction holds back everything behind it.
- R3: `in_ready` is high only when the unit selected by `in_cls` is idle and no in-flight instruction has claimed `in_dst`. Class codes are: 0 load/store, 1 add, 2 multiply, 3 logic. Unit index equals class code.
- R4: After issue, a unit raises its read strobe in the first later cycle in which neither source has an outstanding producer. A producer that writes back in the instruction's own issue cycle is not outstanding.
- R5: The start strobe fires the cycle after the read strobe. The writeback strobe is raised no earlier than L cycles after the start strobe, where L is 2, 2, 3 and 1 for units 0, 1, 2 and 3.
- R6: A finished unit raises its writeback strobe unless an older in-flight instruction, still waiting to read its operands, names the finished unit's destination as a source. While that is true, the writeback is held.
- R7: Several units may write back in the same cycle, and all of them do so if none is held by R6.
- R8: A register's claim is released in the cycle its owner writes back. A dependent instruction may raise its read strobe in the next cycle.
- R9: A unit becomes idle in the cycle it writes back, so a new instruction for it may issue in the next cycle.
- R10: `wb_dst` bits [3u+2:3u] carry the destination register of unit u whenever `wb_fire[u]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head instruction present |
| in_cls | input | 2 | Class of head instruction, which is also its unit index |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| in_ready | output | 1 | Head instruction may issue this cycle |
| issue_fire | output | 1 | Head instruction issues this cycle |
| issue_unit | output | 2 | Unit receiving the issued instruction |
| rd_fire | output | 4 | Per-unit operand read strobe |
| ex_start | output | 4 | Per-unit execution start strobe |
| wb_fire | output | 4 | Per-unit writeback strobe |
| wb_dst | output | 12 | Per-unit writeback destination, 3 bits per unit |

## Verification
The hardest state to reach is a held writeback (R6). It needs a fast unit to finish while an older instruction still sits in the read stage naming the same register, and that older instruction can only be waiting there because of a separate, slower producer. The directed part of the stimulus sets this up with a three-instruction pattern: a multiply feeds an add, the add also reads a register, and a one-cycle logic operation then overwrites that register. A long pseudo-random stream over only eight registers follows, and it hits this case along with same-cycle writebacks and issue-cycle bypasses many times. The behavioural model flags each of these cases, so the bench can confirm they actually occurred.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_READ = 2'd1,
    PH_EXEC = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // execution latency for each unit index
  function automatic int unsigned unit_latency(input int unsigned unit);
    case (unit)
      0:       return 2;
      1:       return 2;
      2:       return 3;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sched_fu_slot.sv
module sched_fu_slot
  import sched_pkg::*;
#(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned LAT     = 2,
  localparam int unsigned FU_W   = $clog2(NUM_FU),
  localparam int unsigned REG_W  = $clog2(NUM_REG),
  localparam int unsigned CNT_W  = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [REG_W-1:0]  iss_src1,
  input  logic [REG_W-1:0]  iss_src2,
  input  logic              iss_pend1,
  input  logic              iss_pend2,
  input  logic [FU_W-1:0]   iss_own1,
  input  logic [FU_W-1:0]   iss_own2,
  input  logic [NUM_FU-1:0] wb_all,
  input  logic              war_hold,
  output logic              busy,
  output logic              reading,
  output logic [REG_W-1:0]  dst,
  output logic [REG_W-1:0]  src1,
  output logic [REG_W-1:0]  src2,
  output logic              rd_pulse,
  output logic              start_pulse,
  output logic              wb_pulse
);

  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  phase_e             phase_q;
  logic               wait1_q, wait2_q;
  logic [FU_W-1:0]    own1_q, own2_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [REG_W-1:0]   dst_q, src1_q, src2_q;

  // named internal events
  logic               wait1_left, wait2_left;

  assign wait1_left  = wait1_q & ~wb_all[own1_q];
  assign wait2_left  = wait2_q & ~wb_all[own2_q];

  assign busy        = (phase_q != PH_IDLE);
  assign reading     = (phase_q == PH_READ);
  assign rd_pulse    = reading & ~wait1_q & ~wait2_q;
  assign start_pulse = (phase_q == PH_EXEC) & (cnt_q == LAT_C);
  assign wb_pulse    = (phase_q == PH_DONE) & ~war_hold;
  assign dst         = dst_q;
  assign src1        = src1_q;
  assign src2        = src2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wait1_q <= 1'b0;
      wait2_q <= 1'b0;
      own1_q  <= '0;
      own2_q  <= '0;
      cnt_q   <= '0;
      dst_q   <= '0;
      src1_q  <= '0;
      src2_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (issue_en) begin
            phase_q <= PH_READ;
            dst_q   <= iss_dst;
            src1_q  <= iss_src1;
            src2_q  <= iss_src2;
            wait1_q <= iss_pend1;
            wait2_q <= iss_pend2;
            own1_q  <= iss_own1;
            own2_q  <= iss_own2;
          end
        end
        PH_READ: begin
          if (rd_pulse) begin
            phase_q <= PH_EXEC;
            cnt_q   <= LAT_C;
          end else begin
            wait1_q <= wait1_left;
            wait2_q <= wait2_left;
          end
        end
        PH_EXEC: begin
          if (cnt_q == ONE_C) phase_q <= PH_DONE;
          cnt_q <= cnt_q - ONE_C;
        end
        default: begin
          if (wb_pulse) phase_q <= PH_IDLE;
        end
      endcase
    end
  end

  AST_START_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> start_pulse); // R5
  AST_IDLE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pulse |=> !busy); // R9
  AST_NO_ISSUE_INTO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !issue_en); // R3

endmodule

// File: rtl/sched_dest_table.sv
module sched_dest_table #(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_REG = 8,
  localparam int unsigned FU_W   = $clog2(NUM_FU),
  localparam int unsigned REG_W  = $clog2(NUM_REG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [REG_W-1:0]              set_reg,
  input  logic [FU_W-1:0]               set_own,
  input  logic [NUM_FU-1:0]             wb_all,
  output logic [NUM_REG-1:0]            resv,
  output logic [NUM_REG-1:0][FU_W-1:0]  owner
);

  logic [NUM_REG-1:0]           resv_q;
  logic [NUM_REG-1:0][FU_W-1:0] own_q;

  assign resv  = resv_q;
  assign owner = own_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_q <= '0;
      own_q  <= '0;
    end else begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (resv_q[r] && wb_all[own_q[r]]) resv_q[r] <= 1'b0;
        if (set_en && (set_reg == REG_W'(r))) begin
          resv_q[r] <= 1'b1;
          own_q[r]  <= set_own;
        end
      end
    end
  end

  AST_CLAIM_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !resv_q[set_reg]); // R3

  for (genvar r = 0; r < NUM_REG; r++) begin : g_chk
    AST_RELEASE_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (resv_q[r] && wb_all[own_q[r]] && !(set_en && set_reg == REG_W'(r))) |=> !resv_q[r]); // R8
  end

endmodule

// File: rtl/sched_war_guard.sv
module sched_war_guard #(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_REG = 8,
  localparam int unsigned FU_W   = $clog2(NUM_FU),
  localparam int unsigned REG_W  = $clog2(NUM_REG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue_en,
  input  logic [FU_W-1:0]               issue_unit,
  input  logic [NUM_FU-1:0]             busy,
  input  logic [NUM_FU-1:0]             reading,
  input  logic [NUM_FU-1:0]             wb_all,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fu_dst,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fu_src1,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fu_src2,
  output logic [NUM_FU-1:0]             war_hold
);

  // older_q[v][u]: the instruction in unit v entered before the one in unit u
  logic [NUM_FU-1:0][NUM_FU-1:0] older_q;

  function automatic logic names_reg(input logic [REG_W-1:0] a,
                                     input logic [REG_W-1:0] b,
                                     input logic [REG_W-1:0] r);
    return (a == r) || (b == r);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (issue_en) begin
      for (int v = 0; v < NUM_FU; v++) begin
        for (int u = 0; u < NUM_FU; u++) begin
          if (issue_unit == FU_W'(u))      older_q[v][u] <= busy[v] & ~wb_all[v];
          else if (issue_unit == FU_W'(v)) older_q[v][u] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    war_hold = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && reading[v] && older_q[v][u] &&
            names_reg(fu_src1[v], fu_src2[v], fu_dst[u]))
          war_hold[u] = 1'b1;
      end
    end
  end

  for (genvar a = 0; a < NUM_FU; a++) begin : g_a
    for (genvar b = a + 1; b < NUM_FU; b++) begin : g_b
      AST_AGE_ANTISYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
        !(older_q[a][b] && older_q[b][a])); // R6
    end
  end

endmodule

// File: rtl/sched_board.sv
module sched_board
  import sched_pkg::*;
#(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_REG = 8,
  localparam int unsigned FU_W   = $clog2(NUM_FU),
  localparam int unsigned REG_W  = $clog2(NUM_REG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [FU_W-1:0]           in_cls,
  input  logic [REG_W-1:0]          in_dst,
  input  logic [REG_W-1:0]          in_src1,
  input  logic [REG_W-1:0]          in_src2,
  output logic                      in_ready,
  output logic                      issue_fire,
  output logic [FU_W-1:0]           issue_unit,
  output logic [NUM_FU-1:0]         rd_fire,
  output logic [NUM_FU-1:0]         ex_start,
  output logic [NUM_FU-1:0]         wb_fire,
  output logic [NUM_FU*REG_W-1:0]   wb_dst
);

  logic [NUM_FU-1:0]             unit_busy, unit_reading, war_hold;
  logic [NUM_FU-1:0][REG_W-1:0]  unit_dst, unit_src1, unit_src2;
  logic [NUM_REG-1:0]            resv;
  logic [NUM_REG-1:0][FU_W-1:0]  resv_owner;
  logic                          pend1, pend2;

  // a source waits only if its owner is not writing it back right now
  function automatic logic src_pending(input logic [NUM_REG-1:0]           rv,
                                       input logic [NUM_REG-1:0][FU_W-1:0] ro,
                                       input logic [NUM_FU-1:0]            wv,
                                       input logic [REG_W-1:0]             r);
    return rv[r] && !wv[ro[r]];
  endfunction

  assign in_ready   = ~unit_busy[in_cls] & ~resv[in_dst];
  assign issue_fire = in_valid & in_ready;
  assign issue_unit = in_cls;
  assign pend1      = src_pending(resv, resv_owner, wb_fire, in_src1);
  assign pend2      = src_pending(resv, resv_owner, wb_fire, in_src2);
  assign wb_dst     = unit_dst;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
    sched_fu_slot #(
      .NUM_FU  (NUM_FU),
      .NUM_REG (NUM_REG),
      .LAT     (unit_latency(g))
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_en    (issue_fire && (in_cls == FU_W'(g))),
      .iss_dst     (in_dst),
      .iss_src1    (in_src1),
      .iss_src2    (in_src2),
      .iss_pend1   (pend1),
      .iss_pend2   (pend2),
      .iss_own1    (resv_owner[in_src1]),
      .iss_own2    (resv_owner[in_src2]),
      .wb_all      (wb_fire),
      .war_hold    (war_hold[g]),
      .busy        (unit_busy[g]),
      .reading     (unit_reading[g]),
      .dst         (unit_dst[g]),
      .src1        (unit_src1[g]),
      .src2        (unit_src2[g]),
      .rd_pulse    (rd_fire[g]),
      .start_pulse (ex_start[g]),
      .wb_pulse    (wb_fire[g])
    );
  end

  sched_dest_table #(
    .NUM_FU  (NUM_FU),
    .NUM_REG (NUM_REG)
  ) u_dest (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue_fire),
    .set_reg (in_dst),
    .set_own (in_cls),
    .wb_all  (wb_fire),
    .resv    (resv),
    .owner   (resv_owner)
  );

  sched_war_guard #(
    .NUM_FU  (NUM_FU),
    .NUM_REG (NUM_REG)
  ) u_war (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_en   (issue_fire),
    .issue_unit (in_cls),
    .busy       (unit_busy),
    .reading    (unit_reading),
    .wb_all     (wb_fire),
    .fu_dst     (unit_dst),
    .fu_src1    (unit_src1),
    .fu_src2    (unit_src2),
    .war_hold   (war_hold)
  );

  for (genvar a = 0; a < NUM_FU; a++) begin : g_wa
    for (genvar b = a + 1; b < NUM_FU; b++) begin : g_wb
      AST_WB_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_fire[a] && wb_fire[b]) |-> (unit_dst[a] != unit_dst[b])); // R7
    end
  end

endmodule

// File: tb/sched_board_tb_top.sv
module sched_board_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_cls;
  logic [2:0]  in_dst, in_src1, in_src2;
  logic        in_ready, issue_fire;
  logic [1:0]  issue_unit;
  logic [3:0]  rd_fire, ex_start, wb_fire;
  logic [11:0] wb_dst;

  always #10 clk = ~clk;

  sched_board dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_ready(in_ready), .issue_fire(issue_fire), .issue_unit(issue_unit),
    .rd_fire(rd_fire), .ex_start(ex_start), .wb_fire(wb_fire), .wb_dst(wb_dst)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int lat(input int u);
    if (u == 2) return 3;
    if (u == 3) return 1;
    return 2;
  endfunction

  // program
  int p_cls[0:511], p_dst[0:511], p_s1[0:511], p_s2[0:511], p_gap[0:511];
  int n_prog = 0;

  task automatic add_ins(input int c, input int d, input int a, input int b, input int gap);
    p_cls[n_prog] = c; p_dst[n_prog] = d; p_s1[n_prog] = a; p_s2[n_prog] = b;
    p_gap[n_prog] = gap; n_prog++;
  endtask

  // driver state
  int idx = 0, bub = 0;
  bit took = 0, run = 0;

  task automatic present();
    if (idx < n_prog) begin
      in_cls = 2'(p_cls[idx]); in_dst = 3'(p_dst[idx]);
      in_src1 = 3'(p_s1[idx]); in_src2 = 3'(p_s2[idx]);
    end
    if (bub > 0) begin in_valid = 1'b0; bub--; end
    else in_valid = (idx < n_prog);
  endtask

  always @(posedge clk) begin
    if (run) begin
      #2;
      if (took) begin
        idx++;
        bub = (idx < n_prog) ? p_gap[idx] : 0;
      end
      present();
    end
  end

  // behavioural model: stage 0 idle, 1 waiting to read, 2 executing, 3 finished
  int m_st[4], m_rem[4], m_p1[4], m_p2[4], m_d[4], m_s1[4], m_s2[4], m_seq[4];
  int m_own[8];
  int seqc = 0;
  bit e_wb[4], e_rd[4], e_go[4], prev_wb[4];
  bit e_iss, e_rdy, any_prev;
  int cov_war = 0, cov_multi = 0, cov_block = 0, cov_rel = 0;

  function automatic bit held(input int u);
    for (int v = 0; v < 4; v++)
      if (v != u && m_st[v] == 1 && m_seq[v] < m_seq[u] &&
          (m_s1[v] == m_d[u] || m_s2[v] == m_d[u])) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 4; u++) begin
      m_st[u] = 0; m_rem[u] = 0; m_p1[u] = -1; m_p2[u] = -1; prev_wb[u] = 0;
    end
    for (int r = 0; r < 8; r++) m_own[r] = -1;
    any_prev = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      int c, dd, a, b, p1n, p2n, nwb;
      took = 0;
      c = int'(in_cls); dd = int'(in_dst); a = int'(in_src1); b = int'(in_src2);
      e_rdy = (m_st[c] == 0) && (m_own[dd] < 0);
      e_iss = in_valid && e_rdy;
      nwb = 0;
      for (int u = 0; u < 4; u++) begin
        e_rd[u] = (m_st[u] == 1) && (m_p1[u] < 0) && (m_p2[u] < 0);
        e_go[u] = (m_st[u] == 2) && (m_rem[u] == lat(u));
        e_wb[u] = (m_st[u] == 3) && !held(u);
        if (e_wb[u]) nwb++;
        if (m_st[u] == 3 && !e_wb[u]) cov_war++;
        if (any_prev && e_rd[u]) cov_rel++;
      end
      if (nwb >= 2) cov_multi++;
      if (in_valid && !e_rdy) cov_block++;

      chk(in_ready === e_rdy, prev_wb[c] ? "R9" : "R3", "in_ready", int'(in_ready), int'(e_rdy));
      chk(issue_fire === e_iss, "R2", "issue_fire", int'(issue_fire), int'(e_iss));
      if (e_iss) chk(int'(issue_unit) == c, "R2", "issue_unit", int'(issue_unit), c);
      for (int u = 0; u < 4; u++) begin
        chk(rd_fire[u] === e_rd[u], any_prev ? "R8" : "R4", $sformatf("rd_fire[%0d]", u),
            int'(rd_fire[u]), int'(e_rd[u]));
        chk(ex_start[u] === e_go[u], "R5", $sformatf("ex_start[%0d]", u),
            int'(ex_start[u]), int'(e_go[u]));
        chk(wb_fire[u] === e_wb[u], (nwb >= 2) ? "R7" : "R6", $sformatf("wb_fire[%0d]", u),
            int'(wb_fire[u]), int'(e_wb[u]));
        if (e_wb[u] && wb_fire[u])
          chk(int'(wb_dst[u*3 +: 3]) == m_d[u], "R10", $sformatf("wb_dst[%0d]", u),
              int'(wb_dst[u*3 +: 3]), m_d[u]);
      end

      // advance to the state after the coming edge
      p1n = (m_own[a] >= 0 && !e_wb[m_own[a]]) ? m_own[a] : -1;
      p2n = (m_own[b] >= 0 && !e_wb[m_own[b]]) ? m_own[b] : -1;
      for (int u = 0; u < 4; u++) begin
        if (e_wb[u]) begin
          m_st[u] = 0;
          if (m_own[m_d[u]] == u) m_own[m_d[u]] = -1;
        end else if (m_st[u] == 1) begin
          if (e_rd[u]) begin m_st[u] = 2; m_rem[u] = lat(u); end
          else begin
            if (m_p1[u] >= 0 && e_wb[m_p1[u]]) m_p1[u] = -1;
            if (m_p2[u] >= 0 && e_wb[m_p2[u]]) m_p2[u] = -1;
          end
        end else if (m_st[u] == 2) begin
          if (m_rem[u] == 1) m_st[u] = 3; else m_rem[u]--;
        end
      end
      if (e_iss) begin
        m_st[c] = 1; m_d[c] = dd; m_s1[c] = a; m_s2[c] = b;
        m_p1[c] = p1n; m_p2[c] = p2n; m_seq[c] = seqc++; m_own[dd] = c;
        took = 1;
      end
      any_prev = 0;
      for (int u = 0; u < 4; u++) begin prev_wb[u] = e_wb[u]; any_prev |= e_wb[u]; end
    end
  end

  function automatic bit all_idle();
    for (int u = 0; u < 4; u++) if (m_st[u] != 0) return 0;
    return 1;
  endfunction

  initial begin
    logic [15:0] lf;
    int cyc;
    rst_n = 1'b0; in_valid = 1'b0; in_cls = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
    model_reset();

    // RAW chain
    add_ins(2, 1, 2, 3, 0); add_ins(1, 4, 1, 5, 0); add_ins(3, 6, 4, 4, 0);
    // WAW on r1 and blocked head
    add_ins(0, 1, 0, 0, 0); add_ins(3, 1, 2, 2, 0);
    // structural: two adds in a row
    add_ins(1, 2, 0, 0, 0); add_ins(1, 3, 0, 0, 0);
    // WAR: add waits on r3 while reading r7; logic rewrites r7
    add_ins(2, 3, 0, 0, 8); add_ins(1, 4, 3, 7, 0); add_ins(3, 7, 0, 0, 0);
    // same-cycle writebacks: mul then add one cycle later
    add_ins(2, 5, 0, 0, 12); add_ins(1, 6, 0, 0, 0);
    // pseudo-random stream
    lf = 16'hACE1;
    for (int i = 0; i < 320; i++) begin
      int g;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      g = (lf[15:13] == 3'd0) ? int'(lf[1:0]) : 0;
      add_ins(int'(lf[1:0] ^ lf[9:8]), int'(lf[4:2]), int'(lf[7:5]), int'(lf[12:10]), g);
    end

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rd_fire == 4'h0 && ex_start == 4'h0 && wb_fire == 4'h0, "R1", "strobes in reset",
        int'({rd_fire, ex_start, wb_fire}), 0);
    chk(in_ready === 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);

    @(posedge clk); #2;
    rst_n = 1'b1;
    idx = 0; bub = p_gap[0]; present(); run = 1;
    @(negedge clk); #1;
    chk(wb_fire == 4'h0 && rd_fire == 4'h0 && ex_start == 4'h0, "R1", "strobes after reset",
        int'({rd_fire, ex_start, wb_fire}), 0);

    cyc = 0;
    while (!(idx >= n_prog && all_idle()) && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (cyc >= 150000) chk(1'b0, "R2", "watchdog expired", cyc, 0);
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk(idx == n_prog, "R2", "instructions issued", idx, n_prog);
    chk(cov_war > 0, "R6", "held writeback observed", cov_war, 1);
    chk(cov_multi > 0, "R7", "same-cycle writebacks observed", cov_multi, 1);
    chk(cov_block > 0, "R2", "blocked head observed", cov_block, 1);
    chk(cov_rel > 0, "R8", "read after release observed", cov_rel, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule